// File: doc/BRIEF.md
# Adaptive FIFO Acquisition Mode Controller

This controller sits between two sensor input FIFOs and the shared read bus that drains them. It watches each FIFO's empty, half-full and full flags. From those flags it estimates how much data has arrived in a programmable window of clock cycles. When the estimate reaches a threshold, it switches from word-by-word polling reads to fixed-size burst reads.

In polling mode the controller reads one word per cycle from whichever FIFO is not empty, and it takes turns between the two FIFOs. In burst mode it waits until a FIFO reports half full and then issues a block of consecutive reads from that FIFO alone. Each sensor's data lands in one of two destination banks, and the bank alternates on every completed burst. When a burst finishes, a one-cycle completion pulse carries a tag naming the sensor and the bank that was just filled. Downstream logic uses this tag to process the correct buffer while the other bank fills.

Top module: `acqm_ctrl`

## Requirements
- R1: After reset the mode output indicates polling (`burst_mode` = 0), `done_valid` is 0, and no read strobe is issued while both FIFOs report empty.
- R2: Each rising edge of a half-full flag adds DEPTH/2 to the rate sum, each rising edge of a full flag adds DEPTH, and a rising edge of an empty flag adds nothing. Edges from both FIFOs add into the same sum.
- R3: A rate window lasts `win_len` clock cycles, counted from reset. At the last cycle of each window, the mode becomes burst (`burst_mode` = 1) if that window's sum is at least `rate_thresh` and polling otherwise. The sum restarts from zero for the next window, and the mode output changes at no other time.
- R4: In polling mode a single word is read (`rd_strobe` = 1) only from a FIFO whose empty flag is low. `rd_sel` = 0 selects FIFO 0 and 1 selects FIFO 1. Turns alternate between the FIFOs, FIFO 0 has the first turn after reset, and a FIFO that is empty on its turn is skipped.
- R5: No read is issued when both FIFOs are empty in polling mode. No single-word reads are issued in burst mode, even when a FIFO is not empty.
- R6: In burst mode a FIFO whose half-full flag is high gets a burst of exactly DEPTH/2 reads on consecutive cycles, all with the same `rd_sel`. Reads from the two FIFOs never interleave.
- R7: In the cycle after the last read of a burst, `done_valid` pulses for one cycle with `done_sensor` naming the FIFO. `done_bank` names the bank just filled; each sensor's bank starts at 0 after reset and alternates with every completed burst of that sensor.
- R8: When both half-full flags are high, bursts alternate between the FIFOs. After reset FIFO 0 is first; after any burst, the other FIFO is preferred.
- R9: A burst that has started runs to its full length even if the mode returns to polling during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_len | input | WIN_W | Rate window length in clock cycles |
| rate_thresh | input | ACC_W | Rate sum at or above which burst mode is chosen |
| fifo_empty | input | 2 | Empty flag of each FIFO, bit i for FIFO i |
| fifo_half | input | 2 | Half-full flag of each FIFO |
| fifo_full | input | 2 | Full flag of each FIFO |
| rd_strobe | output | 1 | Read one word from the selected FIFO this cycle |
| rd_sel | output | 1 | FIFO addressed by the read strobe |
| burst_mode | output | 1 | 1 = burst mode, 0 = polling mode |
| done_valid | output | 1 | One-cycle burst completion pulse |
| done_sensor | output | 1 | FIFO whose burst completed |
| done_bank | output | 1 | Bank that burst filled |

## Verification
The hardest situation to reach from the ports is a mode change that lands in the middle of a burst. The mode only moves at window boundaries, and a burst only starts from a half-full flag. The bench therefore shortens the window to one cycle so the mode follows the threshold almost at once. It waits for the first read of a burst, then raises the threshold to its maximum and drops the flag, and counts the remaining reads to the completion pulse. For the rate estimate, the bench sweeps half-full and full pulse counts against thresholds on and around each possible sum. It checks the mode one cycle before and one cycle after each window boundary.

// File: rtl/acqm_pkg.sv
package acqm_pkg;

    localparam int N_SRC = 2;

    typedef enum logic {
        MODE_POLL  = 1'b0,
        MODE_BURST = 1'b1
    } acq_mode_e;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_BURST = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic empty;
        logic half;
        logic full;
    } fifo_flags_t;

endpackage

// File: rtl/acqm_flag_weigh.sv
module acqm_flag_weigh
    import acqm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flag_empty,
    input  logic             flag_half,
    input  logic             flag_full,
    output logic [ACC_W-1:0] weight
);

    localparam logic [ACC_W-1:0] EMPTY_WT = '0;
    localparam logic [ACC_W-1:0] HALF_WT  = ACC_W'(DEPTH / 2);
    localparam logic [ACC_W-1:0] FULL_WT  = ACC_W'(DEPTH);

    fifo_flags_t prev_q, prev_d;
    fifo_flags_t cur, rise;

    always_comb begin
        cur.empty = flag_empty;
        cur.half  = flag_half;
        cur.full  = flag_full;
        prev_d    = cur;
        rise      = cur & ~prev_q;
        weight    = (rise.empty ? EMPTY_WT : '0)
                  + (rise.half  ? HALF_WT  : '0)
                  + (rise.full  ? FULL_WT  : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/acqm_rate_window.sv
module acqm_rate_window
    import acqm_pkg::*;
#(
    parameter int WIN_W = 8,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    input  logic [ACC_W-1:0] thresh,
    input  logic [ACC_W:0]   inc,
    output acq_mode_e        mode,
    output logic             win_end
);

    localparam int SUM_W = ACC_W + 2;
    localparam logic [SUM_W-1:0] ACC_MAX = SUM_W'({ACC_W{1'b1}});

    typedef struct packed {
        logic [WIN_W-1:0] cnt;
        logic [ACC_W-1:0] acc;
        acq_mode_e        mode;
    } rate_regs_t;

    rate_regs_t q, d;
    logic [SUM_W-1:0] sum;
    logic [WIN_W:0]   cnt_next;

    always_comb begin
        d        = q;
        sum      = SUM_W'(q.acc) + SUM_W'(inc);
        cnt_next = (WIN_W+1)'(q.cnt) + 1'b1;
        win_end  = (cnt_next >= (WIN_W+1)'(win_len));
        if (win_end) begin
            d.cnt  = '0;
            d.acc  = '0;
            d.mode = (sum >= SUM_W'(thresh)) ? MODE_BURST : MODE_POLL;
        end else begin
            d.cnt  = cnt_next[WIN_W-1:0];
            d.acc  = (sum > ACC_MAX) ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
        end
        mode = q.mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/acqm_reader.sv
module acqm_reader
    import acqm_pkg::*;
#(
    parameter int BURST_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acq_mode_e        mode,
    input  logic [N_SRC-1:0] fifo_empty,
    input  logic [N_SRC-1:0] fifo_half,
    output logic             rd_strobe,
    output logic             rd_sel,
    output logic             burst_active,
    output logic             done_valid,
    output logic             done_sensor,
    output logic             done_bank
);

    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_LEN - 1);

    typedef struct packed {
        rd_state_e        st;
        logic             rr;
        logic             bsel;
        logic [BEAT_W-1:0] beat;
        logic [N_SRC-1:0] bank;
        logic             done;
        logic             done_sensor;
        logic             done_bank;
    } rd_regs_t;

    rd_regs_t q, d;

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        rd_strobe = 1'b0;
        rd_sel    = 1'b0;
        unique case (q.st)
            RD_IDLE: begin
                if (mode == MODE_POLL) begin
                    if (!fifo_empty[q.rr]) begin
                        rd_strobe = 1'b1;
                        rd_sel    = q.rr;
                        d.rr      = ~q.rr;
                    end else if (!fifo_empty[~q.rr]) begin
                        rd_strobe = 1'b1;
                        rd_sel    = ~q.rr;
                        d.rr      = q.rr;
                    end
                end else begin
                    if (fifo_half[q.rr]) begin
                        d.st   = RD_BURST;
                        d.bsel = q.rr;
                        d.beat = '0;
                    end else if (fifo_half[~q.rr]) begin
                        d.st   = RD_BURST;
                        d.bsel = ~q.rr;
                        d.beat = '0;
                    end
                end
            end
            RD_BURST: begin
                rd_strobe = 1'b1;
                rd_sel    = q.bsel;
                if (q.beat == LAST_BEAT) begin
                    d.st           = RD_IDLE;
                    d.done         = 1'b1;
                    d.done_sensor  = q.bsel;
                    d.done_bank    = q.bank[q.bsel];
                    d.bank[q.bsel] = ~q.bank[q.bsel];
                    d.rr           = ~q.bsel;
                end else begin
                    d.beat = q.beat + 1'b1;
                end
            end
            default: d.st = RD_IDLE;
        endcase
        burst_active = (q.st == RD_BURST);
        done_valid   = q.done;
        done_sensor  = q.done_sensor;
        done_bank    = q.done_bank;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/acqm_ctrl.sv
module acqm_ctrl
    import acqm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIN_W = 8,
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    input  logic [ACC_W-1:0] rate_thresh,
    input  logic [1:0]       fifo_empty,
    input  logic [1:0]       fifo_half,
    input  logic [1:0]       fifo_full,
    output logic             rd_strobe,
    output logic             rd_sel,
    output logic             burst_mode,
    output logic             done_valid,
    output logic             done_sensor,
    output logic             done_bank
);

    localparam int BURST_LEN = DEPTH / 2;

    logic [ACC_W-1:0] src_wt [N_SRC];
    logic [ACC_W:0]   wt_total;
    acq_mode_e        mode;
    logic             win_end;
    logic             burst_active;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        acqm_flag_weigh #(
            .DEPTH (DEPTH),
            .ACC_W (ACC_W)
        ) u_weigh (
            .clk        (clk),
            .rst_n      (rst_n),
            .flag_empty (fifo_empty[s]),
            .flag_half  (fifo_half[s]),
            .flag_full  (fifo_full[s]),
            .weight     (src_wt[s])
        );
    end

    always_comb begin
        wt_total = '0;
        for (int s = 0; s < N_SRC; s++) begin
            wt_total = wt_total + (ACC_W+1)'(src_wt[s]);
        end
    end

    acqm_rate_window #(
        .WIN_W (WIN_W),
        .ACC_W (ACC_W)
    ) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_len (win_len),
        .thresh  (rate_thresh),
        .inc     (wt_total),
        .mode    (mode),
        .win_end (win_end)
    );

    acqm_reader #(
        .BURST_LEN (BURST_LEN)
    ) u_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .fifo_empty   (fifo_empty),
        .fifo_half    (fifo_half),
        .rd_strobe    (rd_strobe),
        .rd_sel       (rd_sel),
        .burst_active (burst_active),
        .done_valid   (done_valid),
        .done_sensor  (done_sensor),
        .done_bank    (done_bank)
    );

    assign burst_mode = (mode == MODE_BURST);

endmodule

// File: rtl/acqm_ctrl_chk.sv
module acqm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] fifo_empty,
    input logic       rd_strobe,
    input logic       rd_sel,
    input logic       burst_mode,
    input logic       burst_active,
    input logic       win_end,
    input logic       done_valid,
    input logic       done_sensor
);

    // R4: a single-word read never targets an empty FIFO
    a_r4_poll_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !burst_active) |-> !fifo_empty[rd_sel]);

    // R6: while a burst is active a read is issued every cycle
    a_r6_burst_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        burst_active |-> rd_strobe);

    // R7: completion follows a read of the named FIFO
    a_r7_done_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> ($past(rd_strobe) && ($past(rd_sel) == done_sensor)));

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R3: the mode changes only at a window boundary
    a_r3_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !win_end |=> $stable(burst_mode));

endmodule

bind acqm_ctrl acqm_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fifo_empty   (fifo_empty),
    .rd_strobe    (rd_strobe),
    .rd_sel       (rd_sel),
    .burst_mode   (burst_mode),
    .burst_active (burst_active),
    .win_end      (win_end),
    .done_valid   (done_valid),
    .done_sensor  (done_sensor)
);

// File: tb/acqm_ctrl_bench.sv
module acqm_ctrl_bench;

    localparam int DEPTH = 16;
    localparam int LEN   = DEPTH / 2;
    localparam int WIN   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  win_len = 8'd16;
    logic [11:0] rate_thresh = '0;
    logic [1:0]  fifo_empty = 2'b11;
    logic [1:0]  fifo_half = 2'b00;
    logic [1:0]  fifo_full = 2'b00;
    logic        rd_strobe, rd_sel, burst_mode, done_valid, done_sensor, done_bank;

    int n_checks = 0;
    int n_fail = 0;
    logic       brr;
    logic [1:0] bank_exp;

    always #5 clk = ~clk;

    acqm_ctrl #(.DEPTH(DEPTH), .WIN_W(8), .ACC_W(12)) u_acqm_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_len     (win_len),
        .rate_thresh (rate_thresh),
        .fifo_empty  (fifo_empty),
        .fifo_half   (fifo_half),
        .fifo_full   (fifo_full),
        .rd_strobe   (rd_strobe),
        .rd_sel      (rd_sel),
        .burst_mode  (burst_mode),
        .done_valid  (done_valid),
        .done_sensor (done_sensor),
        .done_bank   (done_bank)
    );

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        fifo_empty = 2'b11;
        fifo_half  = 2'b00;
        fifo_full  = 2'b00;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(burst_mode == 1'b0, "R1 mode after reset", int'(burst_mode), 0);
        chk(rd_strobe == 1'b0, "R1 strobe after reset", int'(rd_strobe), 0);
        chk(done_valid == 1'b0, "R1 done after reset", int'(done_valid), 0);
        brr = 1'b0;
        bank_exp = 2'b00;
    endtask

    task automatic rate_case(input int nh, input int nf, input int thr, input bit pe);
        int e = 0;
        int sum;
        win_len = 8'(WIN);
        rate_thresh = 12'(thr);
        do_reset();
        for (int i = 0; i < nh; i++) begin
            fifo_half[i % 2] = 1'b1;
            @(negedge clk);
            fifo_half = 2'b00;
            @(negedge clk);
            e += 2;
        end
        for (int i = 0; i < nf; i++) begin
            fifo_full[(i + 1) % 2] = 1'b1;
            @(negedge clk);
            fifo_full = 2'b00;
            @(negedge clk);
            e += 2;
        end
        if (pe) begin
            fifo_empty[0] = 1'b0;
            @(negedge clk);
            fifo_empty[0] = 1'b1;
            @(negedge clk);
            e += 2;
        end
        repeat (WIN - 1 - e) @(negedge clk);
        #1;
        chk(burst_mode == 1'b0, "R3 mode held before boundary", int'(burst_mode), 0);
        @(negedge clk);
        #1;
        sum = nh * (DEPTH / 2) + nf * DEPTH;
        chk(burst_mode == (sum >= thr), "R2 weighted sum vs threshold",
            int'(burst_mode), int'(sum >= thr));
        repeat (WIN) @(negedge clk);
        #1;
        chk(burst_mode == (thr == 0), "R3 sum cleared for next window",
            int'(burst_mode), int'(thr == 0));
    endtask

    task automatic burst_run(input logic [1:0] pat, input int ndone);
        int got = 0;
        int cnt = 0;
        logic cur = 1'b0;
        logic exp_s;
        fifo_half = pat;
        while (got < ndone) begin
            @(negedge clk);
            #1;
            if (rd_strobe) begin
                if (cnt == 0) cur = rd_sel;
                else if (rd_sel != cur) chk(1'b0, "R6 select changed in burst", int'(rd_sel), int'(cur));
                cnt++;
            end
            if (done_valid) begin
                exp_s = (pat == 2'b11) ? brr : (pat == 2'b10);
                chk(cnt == LEN, "R6 burst length", cnt, LEN);
                chk(cur == exp_s, "R6 burst FIFO", int'(cur), int'(exp_s));
                chk(done_sensor == exp_s, "R8 completed sensor", int'(done_sensor), int'(exp_s));
                chk(done_bank == bank_exp[exp_s], "R7 bank tag", int'(done_bank), int'(bank_exp[exp_s]));
                bank_exp[exp_s] = ~bank_exp[exp_s];
                brr = ~exp_s;
                got++;
                cnt = 0;
            end
        end
    endtask

    initial begin
        logic rr;
        logic exp_sel;
        int   cnt;
        int   extra;

        // rate estimate sweep
        for (int nh = 0; nh < 4; nh++) begin
            for (int nf = 0; nf < 3; nf++) begin
                for (int t = 0; t < 5; t++) begin
                    rate_case(nh, nf, (t == 0) ? 0 : 8 + 16 * (t - 1), (nh == 0 && nf == 0));
                end
            end
        end
        // empty-flag edges alone never reach a threshold of one (R2)
        rate_case(0, 0, 1, 1'b1);

        // polling sweep over every empty-flag pattern
        win_len = 8'(WIN);
        rate_thresh = '1;
        do_reset();
        rr = 1'b0;
        for (int rep = 0; rep < 2; rep++) begin
            for (int p = 0; p < 4; p++) begin
                fifo_empty = 2'(p);
                for (int c = 0; c < 6; c++) begin
                    #1;
                    if (p == 3) begin
                        chk(rd_strobe == 1'b0, "R5 no read when both empty", int'(rd_strobe), 0);
                    end else begin
                        exp_sel = (!fifo_empty[rr]) ? rr : ~rr;
                        chk(rd_strobe == 1'b1, "R4 poll read strobe", int'(rd_strobe), 1);
                        chk(rd_sel == exp_sel, "R4 round-robin select", int'(rd_sel), int'(exp_sel));
                        rr = ~exp_sel;
                    end
                    @(negedge clk);
                end
            end
        end
        chk(burst_mode == 1'b0, "R3 high threshold keeps polling", int'(burst_mode), 0);

        // burst mode: window of one cycle, threshold zero
        win_len = 8'd1;
        rate_thresh = '0;
        do_reset();
        repeat (2) @(negedge clk);
        #1;
        chk(burst_mode == 1'b1, "R3 zero threshold selects burst", int'(burst_mode), 1);
        fifo_empty = 2'b00;
        cnt = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            #1;
            if (rd_strobe) cnt++;
        end
        chk(cnt == 0, "R5 no single reads in burst mode", cnt, 0);
        fifo_empty = 2'b11;

        burst_run(2'b01, 2);
        burst_run(2'b10, 2);
        burst_run(2'b11, 4);

        // mode drops to polling mid-burst (R9)
        fifo_half = 2'b01;
        cnt = 0;
        while (cnt == 0) begin
            @(negedge clk);
            #1;
            if (rd_strobe) cnt = 1;
        end
        rate_thresh = '1;
        fifo_half = 2'b00;
        while (!done_valid) begin
            @(negedge clk);
            #1;
            if (rd_strobe) cnt++;
        end
        chk(cnt == LEN, "R9 burst completes after mode change", cnt, LEN);
        chk(done_sensor == 1'b0, "R9 completed sensor", int'(done_sensor), 0);
        chk(done_bank == bank_exp[0], "R7 bank after interrupted mode", int'(done_bank), int'(bank_exp[0]));
        chk(burst_mode == 1'b0, "R9 mode back to polling", int'(burst_mode), 0);
        extra = 0;
        for (int c = 0; c < 2 * LEN; c++) begin
            @(negedge clk);
            #1;
            if (rd_strobe) extra++;
        end
        chk(extra == 0, "R9 no reads after burst", extra, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule